// File: doc/BRIEF.md
# Bunch Crossing Pattern Generator

This block steps through the slot structure of one collider orbit, one slot per crossing tick. For each slot it presents the slot number and a flag that tells whether the slot carries a filled bunch or is empty. It also raises a pulse on the first slot of each orbit. The fill structure is nested. The smallest repeating piece is a filled run followed by a short gap. Several of these pieces make a train, and each train ends in a longer gap. Trains are grouped into sections. The orbit closes with a final group of trains and a long abort gap.

The system clock normally runs at twice the crossing rate, so a tick-enable input picks the cycles on which the pattern advances. Tying the tick-enable high gives one slot per clock, which suits slow test clocks. The position is held in a small set of nested counters rather than in a per-slot table. A downstream trigger source uses the filled flag to accept only crossings that hold beam. It uses the slot number to label events.

Top module: `bx_pattern_gen`

## Requirements
- R1: The slot number `bxn` starts at 0 and rises by one on every tick, up to 3563. The tick after 3563 returns it to 0, so an orbit has 3564 slots.
- R2: Each filled run lasts 72 slots with `filled` = 1. It is followed by 8 slots with `filled` = 0. `filled` is 1 only inside these 72-slot runs. Slots 0..71 are filled, 72..79 are empty, and 80 is filled.
- R3: A short train is three filled-run/gap pieces followed by 30 more empty slots, 270 slots in all. A long train is four such pieces followed by 31 more empty slots, 351 slots in all. A regular section is two short trains and then one long train. The first three sections repeat this structure and fill slots 0..2672. In each section the long-train gap ends at the section's last slot, so slot 2672 is empty and slot 2673 is filled.
- R4: The tail section runs from slot 2673 to slot 3563. It is three short trains, which end at slot 3482, followed by 81 empty slots. The last filled slot is 3444. One orbit holds 2808 filled slots.
- R5: `orbit_start` is 1 exactly when `bxn` is 0. Slot 0 is always a filled slot.
- R6: On a clock edge where `tick_en` is 0, `bxn`, `filled` and `orbit_start` keep their values. With `tick_en` held at 1, the pattern advances once per clock.
- R7: A synchronous `rst` at a clock edge puts the block on slot 0 at any time, whatever `tick_en` is: `bxn` = 0, `filled` = 1 and `orbit_start` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Crossing tick; the pattern moves one slot on edges where it is high |
| bxn | output | 12 | Current slot number (0..3563 with default parameters) |
| filled | output | 1 | High when the current slot holds a filled bunch |
| orbit_start | output | 1 | High while the current slot is slot 0 |

## Verification
The bench builds the block with its default train, gap and section lengths. With these values the orbit is the full 3564 slots, and every filled/empty boundary at each level of the nesting falls at a known slot number. A full orbit walk therefore reaches the run, train, section and tail-gap edges, as well as the wrap back to slot 0. Ticks come every other clock, as they would from a double-rate clock. Some stretches hold the tick high continuously or low for several cycles, and one stretch applies reset in the middle of an orbit.

// File: rtl/bxp_pkg.sv
package bxp_pkg;

    // Which stretch of the fill structure the current slot belongs to
    typedef enum logic [1:0] {
        PH_FILL      = 2'd0,
        PH_UNIT_GAP  = 2'd1,
        PH_TRAIN_GAP = 2'd2,
        PH_ABORT     = 2'd3
    } bx_phase_e;

    // Per-slot view handed from the sequencer to the top
    typedef struct packed {
        bx_phase_e phase;
        logic      filled;
        logic      last_slot;
    } seq_status_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Slots in one train made of n units plus a closing gap
    function automatic int train_slots(input int fill_len, input int unit_gap,
                                       input int units, input int tail_gap);
        return units * (fill_len + unit_gap) + tail_gap;
    endfunction

    // Slots in a whole orbit
    function automatic int orbit_slots(
        input int fill_len, input int unit_gap,
        input int short_units, input int short_gap,
        input int long_units, input int long_gap,
        input int short_per_sec, input int sections,
        input int tail_trains, input int abort_gap);
        int s_len;
        int l_len;
        s_len = train_slots(fill_len, unit_gap, short_units, short_gap);
        l_len = train_slots(fill_len, unit_gap, long_units, long_gap);
        return sections * (short_per_sec * s_len + l_len)
             + tail_trains * s_len + abort_gap;
    endfunction

endpackage

// File: rtl/bx_run_counter.sv
module bx_run_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] len,
    output logic [W-1:0] count,
    output logic         done
);

    logic [W-1:0] count_q;

    assign done  = (count_q == len - W'(1));
    assign count = count_q;

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (step)
            count_q <= done ? '0 : count_q + W'(1);
    end

    // R2: the position inside a run never reaches the run length
    p_count_range_r2: assert property (@(posedge clk) disable iff (rst)
        count_q < len);

endmodule

// File: rtl/bx_train_sequencer.sv
module bx_train_sequencer
    import bxp_pkg::*;
#(
    parameter int FILL_LEN      = 72,
    parameter int UNIT_GAP      = 8,
    parameter int SHORT_UNITS   = 3,
    parameter int SHORT_GAP     = 30,
    parameter int LONG_UNITS    = 4,
    parameter int LONG_GAP      = 31,
    parameter int SHORT_PER_SEC = 2,
    parameter int SECTIONS      = 3,
    parameter int TAIL_TRAINS   = 3,
    parameter int ABORT_GAP     = 81
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        step,
    output seq_status_t status
);

    localparam int MAX_RUN = max2(max2(FILL_LEN, UNIT_GAP),
                                  max2(max2(SHORT_GAP, LONG_GAP), ABORT_GAP));
    localparam int RUN_W   = $clog2(MAX_RUN + 1);
    localparam int UNIT_W  = $clog2(max2(SHORT_UNITS, LONG_UNITS) + 1);
    localparam int TRAIN_W = $clog2(max2(SHORT_PER_SEC + 1, TAIL_TRAINS) + 1);
    localparam int SEC_W   = $clog2(SECTIONS + 1);

    localparam logic [RUN_W-1:0]   LEN_FILL   = RUN_W'(FILL_LEN);
    localparam logic [RUN_W-1:0]   LEN_UGAP   = RUN_W'(UNIT_GAP);
    localparam logic [RUN_W-1:0]   LEN_SGAP   = RUN_W'(SHORT_GAP);
    localparam logic [RUN_W-1:0]   LEN_LGAP   = RUN_W'(LONG_GAP);
    localparam logic [RUN_W-1:0]   LEN_ABORT  = RUN_W'(ABORT_GAP);
    localparam logic [UNIT_W-1:0]  SHORT_LAST = UNIT_W'(SHORT_UNITS - 1);
    localparam logic [UNIT_W-1:0]  LONG_LAST  = UNIT_W'(LONG_UNITS - 1);
    localparam logic [TRAIN_W-1:0] LONG_SLOT  = TRAIN_W'(SHORT_PER_SEC);
    localparam logic [TRAIN_W-1:0] TAIL_LAST  = TRAIN_W'(TAIL_TRAINS - 1);
    localparam logic [SEC_W-1:0]   TAIL_SEC   = SEC_W'(SECTIONS);

    bx_phase_e          phase_q, phase_d;
    logic [UNIT_W-1:0]  unit_q,  unit_d;
    logic [TRAIN_W-1:0] train_q, train_d;
    logic [SEC_W-1:0]   sec_q,   sec_d;

    logic               in_tail;
    logic               long_train;
    logic [UNIT_W-1:0]  unit_last;
    logic [RUN_W-1:0]   run_len;
    logic [RUN_W-1:0]   run_pos;
    logic               run_done;

    assign in_tail    = (sec_q == TAIL_SEC);
    assign long_train = !in_tail && (train_q == LONG_SLOT);
    assign unit_last  = long_train ? LONG_LAST : SHORT_LAST;

    always_comb begin
        unique case (phase_q)
            PH_FILL:      run_len = LEN_FILL;
            PH_UNIT_GAP:  run_len = LEN_UGAP;
            PH_TRAIN_GAP: run_len = long_train ? LEN_LGAP : LEN_SGAP;
            default:      run_len = LEN_ABORT;
        endcase
    end

    bx_run_counter #(.W(RUN_W)) u_run (
        .clk   (clk),
        .rst   (rst),
        .step  (step),
        .len   (run_len),
        .count (run_pos),
        .done  (run_done)
    );

    always_comb begin
        phase_d = phase_q;
        unit_d  = unit_q;
        train_d = train_q;
        sec_d   = sec_q;
        if (step && run_done) begin
            unique case (phase_q)
                PH_FILL: phase_d = PH_UNIT_GAP;
                PH_UNIT_GAP: begin
                    if (unit_q == unit_last) begin
                        unit_d  = '0;
                        phase_d = PH_TRAIN_GAP;
                    end else begin
                        unit_d  = unit_q + UNIT_W'(1);
                        phase_d = PH_FILL;
                    end
                end
                PH_TRAIN_GAP: begin
                    phase_d = PH_FILL;
                    if (in_tail) begin
                        if (train_q == TAIL_LAST) begin
                            train_d = '0;
                            phase_d = PH_ABORT;
                        end else begin
                            train_d = train_q + TRAIN_W'(1);
                        end
                    end else if (long_train) begin
                        train_d = '0;
                        sec_d   = sec_q + SEC_W'(1);
                    end else begin
                        train_d = train_q + TRAIN_W'(1);
                    end
                end
                default: begin
                    phase_d = PH_FILL;
                    unit_d  = '0;
                    train_d = '0;
                    sec_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FILL;
            unit_q  <= '0;
            train_q <= '0;
            sec_q   <= '0;
        end else begin
            phase_q <= phase_d;
            unit_q  <= unit_d;
            train_q <= train_d;
            sec_q   <= sec_d;
        end
    end

    assign status.phase     = phase_q;
    assign status.filled    = (phase_q == PH_FILL);
    assign status.last_slot = (phase_q == PH_ABORT) && run_done;

    // R4: leaving the abort gap restarts the outermost structure
    p_abort_restart_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_ABORT && step && run_done)
        |=> (phase_q == PH_FILL && sec_q == '0 && train_q == '0));

    // R6: without a tick the nesting state stays put
    p_seq_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(phase_q) && $stable(unit_q)
                   && $stable(train_q) && $stable(sec_q)));

    // R3: the tail section is only left through the abort gap
    p_tail_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (in_tail && phase_q != PH_ABORT) |=> (in_tail || sec_q == '0));

endmodule

// File: rtl/bx_number_counter.sv
module bx_number_counter #(
    parameter int SLOTS = 3564,
    parameter int W     = $clog2(SLOTS)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] number,
    output logic         at_zero
);

    localparam logic [W-1:0] LAST = W'(SLOTS - 1);

    logic [W-1:0] num_q;

    always_ff @(posedge clk) begin
        if (rst)
            num_q <= '0;
        else if (step)
            num_q <= (num_q == LAST) ? '0 : num_q + W'(1);
    end

    assign number  = num_q;
    assign at_zero = (num_q == '0);

    // R1: the number never leaves the orbit range and wraps after the last slot
    p_range_r1: assert property (@(posedge clk) disable iff (rst)
        num_q <= LAST);
    p_wrap_r1: assert property (@(posedge clk) disable iff (rst)
        (step && num_q == LAST) |=> (num_q == '0));

    // R6: no tick, no movement
    p_num_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(num_q));

endmodule

// File: rtl/bx_pattern_gen.sv
module bx_pattern_gen
    import bxp_pkg::*;
#(
    parameter int FILL_LEN      = 72,
    parameter int UNIT_GAP      = 8,
    parameter int SHORT_UNITS   = 3,
    parameter int SHORT_GAP     = 30,
    parameter int LONG_UNITS    = 4,
    parameter int LONG_GAP      = 31,
    parameter int SHORT_PER_SEC = 2,
    parameter int SECTIONS      = 3,
    parameter int TAIL_TRAINS   = 3,
    parameter int ABORT_GAP     = 81,
    localparam int ORBIT = orbit_slots(FILL_LEN, UNIT_GAP, SHORT_UNITS,
                                       SHORT_GAP, LONG_UNITS, LONG_GAP,
                                       SHORT_PER_SEC, SECTIONS,
                                       TAIL_TRAINS, ABORT_GAP),
    localparam int BXN_W = $clog2(ORBIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    output logic [BXN_W-1:0] bxn,
    output logic             filled,
    output logic             orbit_start
);

    localparam logic [BXN_W-1:0] LAST_BX = BXN_W'(ORBIT - 1);

    seq_status_t seq_st;

    bx_train_sequencer #(
        .FILL_LEN      (FILL_LEN),
        .UNIT_GAP      (UNIT_GAP),
        .SHORT_UNITS   (SHORT_UNITS),
        .SHORT_GAP     (SHORT_GAP),
        .LONG_UNITS    (LONG_UNITS),
        .LONG_GAP      (LONG_GAP),
        .SHORT_PER_SEC (SHORT_PER_SEC),
        .SECTIONS      (SECTIONS),
        .TAIL_TRAINS   (TAIL_TRAINS),
        .ABORT_GAP     (ABORT_GAP)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .step   (tick_en),
        .status (seq_st)
    );

    bx_number_counter #(.SLOTS(ORBIT), .W(BXN_W)) u_num (
        .clk     (clk),
        .rst     (rst),
        .step    (tick_en),
        .number  (bxn),
        .at_zero (orbit_start)
    );

    assign filled = seq_st.filled;

    // R4: the nested structure and the flat counter agree on the orbit end
    p_orbit_align_r4: assert property (@(posedge clk) disable iff (rst)
        seq_st.last_slot == (bxn == LAST_BX));

    // R5: the first slot of an orbit is a filled one
    p_start_filled_r5: assert property (@(posedge clk) disable iff (rst)
        orbit_start |-> filled);

    // R7: reset lands on slot 0 with a filled bunch
    p_reset_state_r7: assert property (@(posedge clk)
        rst |=> (bxn == '0 && filled && orbit_start));

endmodule

// File: tb/bx_pattern_gen_bench.sv
module bx_pattern_gen_bench;

    localparam int ORBIT_N  = 3564;
    localparam int N_VEC    = 20;
    localparam int WD_LIMIT = 100000;

    // slot number and expected filled flag, from R2..R4
    localparam int VEC_SLOT [N_VEC] = '{0, 71, 72, 79, 80, 231, 232, 269,
        270, 540, 851, 852, 890, 891, 2672, 2673, 3444, 3445, 3483, 3563};
    localparam int VEC_FILL [N_VEC] = '{1, 1, 0, 0, 1, 1, 0, 0,
        1, 1, 1, 0, 0, 1, 0, 1, 1, 0, 0, 0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic [11:0] bxn;
    logic        filled;
    logic        orbit_start;

    int total = 0;
    int bad = 0;
    int exp_slot = 0;
    int fill_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bx_pattern_gen u_bx_pattern_gen (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .bxn         (bxn),
        .filled      (filled),
        .orbit_start (orbit_start)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d (time %0t)", req, act, exp, $time);
        end
    endtask

    // one tick on a single clock edge, then an idle edge (half-rate crossing)
    task automatic tick_once();
        @(negedge clk);
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        exp_slot = (exp_slot + 1) % ORBIT_N;
        if (filled) fill_seen++;
        check(int'(bxn) == exp_slot, "R1 number step", int'(bxn), exp_slot);
    endtask

    initial begin
        #(WD_LIMIT * 10);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R7: reset state
        check(bxn == 12'd0, "R7 reset bxn", int'(bxn), 0);
        check(filled == 1'b1, "R7 reset filled", int'(filled), 1);
        check(orbit_start == 1'b1, "R7 reset orbit_start", int'(orbit_start), 1);
        fill_seen = 1;

        // vector table walked in slot order over a full orbit (R2, R3, R4)
        for (int i = 0; i < N_VEC; i++) begin
            while (exp_slot != VEC_SLOT[i]) tick_once();
            check(int'(filled) == VEC_FILL[i], $sformatf("R2/R3/R4 filled at slot %0d", VEC_SLOT[i]),
                  int'(filled), VEC_FILL[i]);
            check(int'(orbit_start) == (VEC_SLOT[i] == 0 ? 1 : 0), "R5 orbit_start level",
                  int'(orbit_start), (VEC_SLOT[i] == 0 ? 1 : 0));
        end

        // R4: filled slots per orbit
        check(fill_seen == 2808, "R4 filled count", fill_seen, 2808);

        // R1 wrap and R5 pulse
        tick_once();
        check(bxn == 12'd0, "R1 wrap to 0", int'(bxn), 0);
        check(orbit_start == 1'b1, "R5 orbit_start at 0", int'(orbit_start), 1);
        check(filled == 1'b1, "R5 slot 0 filled", int'(filled), 1);
        tick_once();
        check(orbit_start == 1'b0, "R5 orbit_start low at 1", int'(orbit_start), 0);

        // R6: tick low holds everything
        begin
            int held;
            held = int'(bxn);
            repeat (6) @(negedge clk);
            check(int'(bxn) == held, "R6 hold bxn", int'(bxn), held);
            check(filled == 1'b1, "R6 hold filled", int'(filled), 1);
        end

        // R6: tick held high advances once per clock (slot 1 -> 4, then 71 -> 72 edge)
        @(negedge clk);
        tick_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        exp_slot = 4;
        check(bxn == 12'd4, "R6 continuous tick", int'(bxn), 4);
        while (exp_slot != 72) tick_once();
        check(filled == 1'b0, "R2 gap after continuous ticks", int'(filled), 0);

        // R7: reset mid-orbit with tick high
        while (exp_slot != 500) tick_once();
        @(negedge clk);
        rst = 1'b1;
        tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        tick_en = 1'b0;
        exp_slot = 0;
        check(bxn == 12'd0, "R7 mid-orbit reset bxn", int'(bxn), 0);
        check(filled == 1'b1, "R7 mid-orbit reset filled", int'(filled), 1);
        check(orbit_start == 1'b1, "R7 mid-orbit reset orbit_start", int'(orbit_start), 1);
        tick_once();
        check(bxn == 12'd1, "R1 step after reset", int'(bxn), 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule